// File: doc/BRIEF.md
# Programmable-Period Shift-Register Clock Divider

The block divides its clock by a selectable ratio between 9 and 15 and emits one single-cycle pulse per period. The sequencer is a 4-stage shift register with exclusive-OR feedback, which by itself walks through all 15 non-zero states. A 3-bit select input shortens the walk in one of two ways. It can force a 1 into the first stage in one decoded state, which jumps over a run of states. For the divide-by-14 setting, it instead forces a 0 into the first stage in one decoded state.

The register contents are visible on `q` and can be decoded externally. The pulse `tick` fires in a state that every selectable loop passes through. A typical use is a bit-rate or frame timer. At a ratio of 11, one tick marks each word of a serial format with one start bit, eight data bits and two stop bits. The select is meant to be set while `preset` is held and left alone afterwards.

Top module: `lfsr_div`

## Requirements
- R1: On a clock edge where `preset` is 1, all four stages load 1 (`q` = 4'b1111). Operation continues from that state.
- R2: On every clock edge without `preset`, stage 0 moves into stage 1, stage 1 into stage 2, and stage 2 into stage 3. `q[i]` holds stage i.
- R3: With `sel` = 0 or `sel` = 7, the stage-0 input is stage 2 XOR stage 3. The state sequence from 4'b1111 is then a 15-state loop, and ticks are 15 clocks apart.
- R4: With `sel` = 1, 2, 3, 4 or 5, the period is 9, 10, 11, 12 or 13 clocks. A 1 is ORed into the stage-0 input when the state matches one decode. Decodes are written as stage values: 1 needs Q0=0 and Q3=0. 2 needs Q0=1, Q1=1 and Q2=0. 3 needs Q0=0 and Q1=0. 4 needs Q0=1, Q1=0 and Q2=0. 5 needs Q0=1, Q1=0 and Q2=1.
- R5: With `sel` = 6, the stage-0 input is forced to 0 whenever Q0, Q1 and Q2 are all 1. The loop then has 14 states and never revisits 4'b1111 after leaving it.
- R6: `tick` is 1 exactly when Q0=1, Q1=1, Q2=1 and Q3=0 (`q` = 4'b0111). It is never high on two consecutive clocks. After a preset edge, the first tick comes P-1 clocks later for period P, except `sel` = 6, where it comes 14 clocks later.
- R7: Once preset, the register never holds the all-zero state for any select value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| preset | input | 1 | Synchronous preset to all ones, active high |
| sel | input | 3 | Period select; sel[0], sel[1], sel[2] are the three control lines |
| q | output | 4 | Register stages, bit i = stage i |
| tick | output | 1 | One-clock pulse per period |

## Verification
The period and skip properties assume that `sel` only changes on a clock where `preset` is high. The interval counter in the checker discards its history whenever `sel` moves or a preset occurs. The stimulus applies each select value together with a one-clock preset and holds it through several complete periods before the next preset. No select change ever falls inside a running count. The properties also assume at least one preset has been seen, so the bench presets before any other activity.

// File: rtl/lfsr_div_pkg.sv
package lfsr_div_pkg;

  localparam int unsigned STAGES = 4;
  localparam int unsigned SEL_W  = 3;
  localparam int unsigned CNT_W  = 5;

  typedef enum logic [2:0] {
    MODE_FULL = 3'd0,
    MODE_P9   = 3'd1,
    MODE_P10  = 3'd2,
    MODE_P11  = 3'd3,
    MODE_P12  = 3'd4,
    MODE_P13  = 3'd5,
    MODE_P14  = 3'd6
  } mode_e;

  // Select code to sequencer mode; unused codes fall back to the full loop.
  function automatic mode_e sel_to_mode(input logic [SEL_W-1:0] s);
    mode_e m;
    case (s)
      3'd1:    m = MODE_P9;
      3'd2:    m = MODE_P10;
      3'd3:    m = MODE_P11;
      3'd4:    m = MODE_P12;
      3'd5:    m = MODE_P13;
      3'd6:    m = MODE_P14;
      default: m = MODE_FULL;
    endcase
    return m;
  endfunction

  // Loop length in clocks for a select code.
  function automatic logic [CNT_W-1:0] period_of(input logic [SEL_W-1:0] s);
    logic [CNT_W-1:0] p;
    case (s)
      3'd1, 3'd2, 3'd3, 3'd4, 3'd5, 3'd6: p = CNT_W'(8) + CNT_W'(s);
      default:                            p = CNT_W'(15);
    endcase
    return p;
  endfunction

  // Unmodified maximal-length feedback bit.
  function automatic logic base_fb(input logic [STAGES-1:0] q);
    return q[2] ^ q[3];
  endfunction

  // State in which a 1 is forced into stage 0 to jump ahead.
  function automatic logic skip_decode(input mode_e m, input logic [STAGES-1:0] q);
    logic hit;
    case (m)
      MODE_P9:  hit = !q[0] && !q[3];
      MODE_P10: hit =  q[0] &&  q[1] && !q[2];
      MODE_P11: hit = !q[0] && !q[1];
      MODE_P12: hit =  q[0] && !q[1] && !q[2];
      MODE_P13: hit =  q[0] && !q[1] &&  q[2];
      default:  hit = 1'b0;
    endcase
    return hit;
  endfunction

  // State in which stage 0 is forced to 0 (divide-by-14 only).
  function automatic logic kill_decode(input mode_e m, input logic [STAGES-1:0] q);
    return (m == MODE_P14) && q[0] && q[1] && q[2];
  endfunction

  // Period marker state: Q0..Q2 high, Q3 low.
  function automatic logic is_tick_state(input logic [STAGES-1:0] q);
    return q == 4'b0111;
  endfunction

endpackage

// File: rtl/lfsr_div_mode.sv
module lfsr_div_mode
  import lfsr_div_pkg::*;
(
  input  logic [SEL_W-1:0] sel,
  output mode_e            mode
);
  always_comb mode = sel_to_mode(sel);
endmodule

// File: rtl/lfsr_div_fb.sv
module lfsr_div_fb
  import lfsr_div_pkg::*;
(
  input  mode_e             mode,
  input  logic [STAGES-1:0] q,
  output logic              skip_hit,
  output logic              kill_hit,
  output logic              fb
);
  logic xor_term;

  always_comb begin
    xor_term = base_fb(q);
    skip_hit = skip_decode(mode, q);
    kill_hit = kill_decode(mode, q);
    fb       = kill_hit ? 1'b0 : (xor_term | skip_hit);
  end
endmodule

// File: rtl/lfsr_div_shift.sv
module lfsr_div_shift #(
  parameter int unsigned N = 4
) (
  input  logic         clk,
  input  logic         preset,
  input  logic         din,
  output logic [N-1:0] q
);
  genvar i;
  generate
    for (i = 0; i < N; i++) begin : g_stage
      logic d;
      if (i == 0) begin : g_head
        assign d = din;
      end else begin : g_link
        assign d = q[i-1];
      end
      always_ff @(posedge clk) begin
        if (preset) q[i] <= 1'b1;
        else        q[i] <= d;
      end
    end
  endgenerate
endmodule

// File: rtl/lfsr_div.sv
module lfsr_div
  import lfsr_div_pkg::*;
(
  input  logic             clk,
  input  logic             preset,
  input  logic [SEL_W-1:0] sel,
  output logic [STAGES-1:0] q,
  output logic             tick
);
  mode_e mode;
  logic  skip_hit;
  logic  kill_hit;
  logic  fb;

  lfsr_div_mode u_mode (
    .sel  (sel),
    .mode (mode)
  );

  lfsr_div_fb u_fb (
    .mode     (mode),
    .q        (q),
    .skip_hit (skip_hit),
    .kill_hit (kill_hit),
    .fb       (fb)
  );

  lfsr_div_shift #(.N(STAGES)) u_shift (
    .clk    (clk),
    .preset (preset),
    .din    (fb),
    .q      (q)
  );

  always_comb tick = is_tick_state(q);
endmodule

// File: rtl/lfsr_div_chk.sv
module lfsr_div_chk
  import lfsr_div_pkg::*;
(
  input logic             clk,
  input logic             preset,
  input logic [SEL_W-1:0] sel,
  input logic [STAGES-1:0] q,
  input logic             tick,
  input logic             skip_hit,
  input logic             kill_hit
);
  logic             armed = 1'b0;
  logic             valid = 1'b0;
  logic [CNT_W-1:0] cnt   = '0;
  logic [SEL_W-1:0] sel_q = '0;

  always_ff @(posedge clk) begin
    armed <= armed | preset;
    sel_q <= sel;
    if (preset || sel != sel_q) begin
      valid <= 1'b0;
      cnt   <= '0;
    end else if (tick) begin
      valid <= 1'b1;
      cnt   <= CNT_W'(1);
    end else if (cnt != '1) begin
      cnt   <= cnt + CNT_W'(1);
    end
  end

  p_preset_ones_r1: assert property (@(posedge clk) disable iff (!armed)
    preset |=> q == 4'b1111);

  p_shift_chain_r2: assert property (@(posedge clk) disable iff (!armed || preset)
    !preset |=> q[3:1] == $past(q[2:0]));

  p_tick_interval_r4: assert property (@(posedge clk) disable iff (!armed || preset)
    (tick && valid && sel == sel_q) |-> cnt == period_of(sel));

  p_skip_sets_head_r4: assert property (@(posedge clk) disable iff (!armed || preset)
    (skip_hit && sel == sel_q) |=> q[0]);

  p_p14_wrap_r5: assert property (@(posedge clk) disable iff (!armed || preset)
    (kill_hit && sel == 3'd6) |=> q == 4'b1110);

  p_tick_width_r6: assert property (@(posedge clk) disable iff (!armed || preset)
    tick |=> !tick);

  p_never_zero_r7: assert property (@(posedge clk) disable iff (!armed || preset)
    q != '0);
endmodule

bind lfsr_div lfsr_div_chk u_chk (
  .clk      (clk),
  .preset   (preset),
  .sel      (sel),
  .q        (q),
  .tick     (tick),
  .skip_hit (skip_hit),
  .kill_hit (kill_hit)
);

// File: tb/lfsr_div_tb.sv
module lfsr_div_tb;
  logic       clk = 1'b0;
  logic       preset = 1'b0;
  logic [2:0] sel = 3'd0;
  logic [3:0] q;
  logic       tick;

  int n_checks = 0;
  int n_fail   = 0;
  int k        = 0;
  bit done     = 1'b0;
  bit started  = 1'b0;
  int exp_q[$];
  logic [3:0] model;

  lfsr_div u_dut (.clk(clk), .preset(preset), .sel(sel), .q(q), .tick(tick));

  always #5 clk = ~clk;

  // Stage values (Q0,Q1,Q2,Q3) packed as q[0..3].
  function automatic logic [3:0] st(input bit a, input bit b, input bit c, input bit d);
    return {d, c, b, a};
  endfunction

  function automatic int period_for(input logic [2:0] s);
    int tbl[8] = '{15, 9, 10, 11, 12, 13, 14, 15};
    return tbl[s];
  endfunction

  function automatic string req_for(input logic [2:0] s);
    if (s == 3'd0 || s == 3'd7) return "R3";
    if (s == 3'd6) return "R5";
    return "R4";
  endfunction

  // Successor: plain shift with XOR feed, then the listed jumps per select.
  function automatic logic [3:0] succ(input logic [3:0] v, input logic [2:0] s);
    logic [3:0] n;
    n = {v[2:0], v[3] ^ v[2]};
    case (s)
      3'd1: if (v == st(0,1,0,0)) n = st(1,0,1,0);
      3'd2: if (v == st(1,1,0,0)) n = st(1,1,1,0);
      3'd3: if (v == st(0,0,1,1)) n = st(1,0,0,1);
      3'd4: if (v == st(1,0,0,0)) n = st(1,1,0,0);
      3'd5: if (v == st(1,0,1,1)) n = st(1,1,0,1);
      3'd6: if (v == st(1,1,1,0)) n = st(0,1,1,1);
      default: ;
    endcase
    return n;
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, expv);
    end
  endtask

  // Driver: preset with the new select, queue the cycles where ticks are due.
  task automatic run_sel(input logic [2:0] s, input int pulses);
    int p;
    int first;
    p = period_for(s);
    first = (s == 3'd6) ? 14 : p - 1;
    @(negedge clk);
    for (int i = 0; i < pulses; i++) exp_q.push_back(first + i * p);
    sel = s;
    preset = 1'b1;
    @(negedge clk);
    preset = 1'b0;
    while (exp_q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  // Monitor: samples shortly after each rising edge.
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (preset) begin
        k = 0;
        started = 1'b1;
        model = 4'b1111;
        check(q == 4'b1111, "R1", "state after preset", int'(q), 15);
      end else if (started) begin
        k++;
        model = succ(model, sel);
        check(q == model, (k == 1) ? "R2" : req_for(sel), "state", int'(q), int'(model));
        check(q != 4'b0000, "R7", "all-zero state", int'(q), 1);
        if (sel == 3'd6 && k > 1)
          check(q != 4'b1111, "R5", "preset state revisited", int'(q), 7);
        if (exp_q.size() > 0 && k == exp_q[0]) begin
          check(tick == 1'b1, req_for(sel), "tick due", int'(tick), 1);
          void'(exp_q.pop_front());
        end else begin
          check(tick == 1'b0, "R6", "tick off-slot", int'(tick), 0);
        end
      end
    end
  end

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual 0 expected 1");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  initial begin
    repeat (2) @(negedge clk);
    run_sel(3'd0, 4);  // R3 full loop
    run_sel(3'd1, 6);  // R4 divide by 9, over 40 clocks for R7
    run_sel(3'd2, 5);  // R4
    run_sel(3'd3, 5);  // R4 eleven-bit serial framing interval
    run_sel(3'd4, 5);  // R4
    run_sel(3'd5, 5);  // R4
    run_sel(3'd6, 5);  // R5 first tick at 14, then every 14
    run_sel(3'd7, 4);  // R3 second full-period code
    run_sel(3'd3, 2);  // R1 preset in the middle of operation restarts cleanly
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule